// File: doc/BRIEF.md
# Encoder Accelerator Host Command and Status Port

This block sits between a host register bus and the task engine of a video-encode accelerator. The host builds each job from two writes to one command-queue address: a header word that carries a task number, a client number and a command type, then a descriptor address. Each complete pair is queued and handed to the task engine over a valid/ready channel. The engine only receives a command when the clock-enable bit for the engine that the command type selects is set.

When a task finishes, the engine returns an 8-bit result code over a second valid/ready channel. The block tags that code with the task and client numbers of the finished job and queues the word for the host. The host drains these words by reading the status-queue register and can read the queue fill level. Two cases are answered by the block itself, without the engine: a command type that names no engine, and a command that arrives while the command queue is full. A sticky task-done interrupt and a sticky error interrupt are both cleared by one acknowledge write. Three memory-error capture registers, several configuration registers, a soft-flush register and a read-only version register complete the map.

Back-pressure rules: on the command channel `eng_cmd_valid` stays high, with word and descriptor stable, until the engine raises `eng_cmd_ready`. Only one task is outstanding at a time. On the result channel the engine must hold `eng_res_valid` and `eng_res_code` until `eng_res_ready` is high. `eng_res_ready` is low while the status queue is full, and also in any cycle where a list-full report takes the status-queue slot.

Top module: `enc_host_if`

## Requirements
- R1: After reset, both interrupts are low, the clock-enable field reads 0, the level register reads 0, a status-queue read returns 0 and no command is offered to the engine.
- R2: Two writes to offset 0x114 form one command: header first (task [31:16], client [15:8], type [7:0]), then descriptor. The engine sees the header on `eng_cmd_word` and the descriptor on `eng_cmd_desc`, and both stay stable while the engine stalls.
- R3: Type 0x01 needs clock-enable bit 0, type 0x02 needs bit 1 and type 0x03 needs bit 2 (register 0x148). A command is offered to the engine only while its bit is set, and the commands behind it wait.
- R4: A command of any other type is not offered to the engine. The block queues the status word {task, client, 0xF1} for it.
- R5: A finished task queues the status word {task [31:16], client [15:8], engine code [7:0]}. At most one task is outstanding, and status words leave in the order they were queued.
- R6: A read of offset 0x118 returns the oldest status word and removes it. A read of an empty queue returns 0 and removes nothing. Read data appears on `bus_rdata` one clock after the read request.
- R7: Offset 0x11C returns the number of queued status words in bits [3:0], with all other bits 0.
- R8: A command that completes while the command queue already holds CMD_DEPTH entries is discarded, and {task, client, 0xF0} is queued in its place.
- R9: `irq_done` rises when a status word is queued and stays high until the host writes bit 0 = 1 to offset 0x120. The same write also clears `irq_err`.
- R10: Error inputs are OR-accumulated into the capture registers at 0x128 (local), 0x12C (external) and 0x130 (secondary). Reading a register returns its value and clears it. Any nonzero error input sets `irq_err` on the next clock.
- R11: Offset 0x14C reads VERSION_ID in bits [15:0] and 0 above, and writes to it have no effect.
- R12: Offsets 0x108, 0x10C and 0x150 are 32-bit read/write and drive `mif_cfg`, `mif2_cfg` and `bswap_cfg`. Offset 0x148 keeps bits [2:0] and drives `gate_en`.
- R13: Writing bit 0 = 1 to offset 0x100 empties both queues and drops a half-written command. After that, offset 0x104 reads 1 once and then reads 0.
- R14: While the status queue is full, `eng_res_ready` stays low and the result is held. It is accepted once the host frees a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after a read |
| eng_cmd_valid | output | 1 | Command offered to the engine |
| eng_cmd_ready | input | 1 | Engine accepts the command |
| eng_cmd_word | output | 32 | Command header |
| eng_cmd_desc | output | 32 | Task descriptor address |
| eng_res_valid | input | 1 | Engine result available |
| eng_res_ready | output | 1 | Result accepted |
| eng_res_code | input | 8 | Engine result code |
| err_local_in | input | 32 | Local memory error event bits |
| err_ext_in | input | 32 | External memory error event bits |
| err_sec_in | input | 32 | Secondary memory error event bits |
| irq_done | output | 1 | Task-done interrupt |
| irq_err | output | 1 | Error interrupt |
| gate_en | output | 3 | Engine clock enables |
| mif_cfg | output | 32 | Memory interface configuration |
| mif2_cfg | output | 32 | Secondary memory interface configuration |
| bswap_cfg | output | 32 | Byte-swap configuration |

## Verification
Most wrong internal state in this block first shows up as a status word that differs from the expected {task, client, code}. A lost header, a pairing that has slipped by one write, or a stale in-flight identifier all appear as a wrong word or as a level count that is too high or too low at the next read of offset 0x11C or 0x118, a few clocks after the second command write. A wrong clock-enable decode shows as a command offered to the engine, or withheld from it, within one clock of the clock-enable write. A broken back-pressure path shows as `eng_res_ready` going high while the level still reads full. Flag errors show as an interrupt that drops without an acknowledge, or that fails to rise one clock after its event.

// File: rtl/enc_host_pkg.sv
package enc_host_pkg;

  localparam logic [11:0] OFS_SRST     = 12'h100;
  localparam logic [11:0] OFS_SRST_ACK = 12'h104;
  localparam logic [11:0] OFS_MIF      = 12'h108;
  localparam logic [11:0] OFS_MIF2     = 12'h10C;
  localparam logic [11:0] OFS_CMDQ     = 12'h114;
  localparam logic [11:0] OFS_STATQ    = 12'h118;
  localparam logic [11:0] OFS_LEVEL    = 12'h11C;
  localparam logic [11:0] OFS_IRQACK   = 12'h120;
  localparam logic [11:0] OFS_ERR_LOC  = 12'h128;
  localparam logic [11:0] OFS_ERR_EXT  = 12'h12C;
  localparam logic [11:0] OFS_ERR_SEC  = 12'h130;
  localparam logic [11:0] OFS_GATE     = 12'h148;
  localparam logic [11:0] OFS_VER      = 12'h14C;
  localparam logic [11:0] OFS_BSWAP    = 12'h150;

  localparam logic [7:0] CODE_LIST_FULL = 8'hF0;
  localparam logic [7:0] CODE_BAD_CMD   = 8'hF1;

  localparam logic [7:0] TYPE_MAIN   = 8'h01;
  localparam logic [7:0] TYPE_COPROC = 8'h02;
  localparam logic [7:0] TYPE_STILL  = 8'h03;

  localparam int unsigned N_ENGINES = 3;
  localparam int unsigned N_ERR     = 3;

  typedef struct packed {
    logic [15:0] task_id;
    logic [7:0]  client_id;
    logic [7:0]  low8;
  } host_word_t;

  // One-hot engine selection for a command type; zero for an unknown type.
  function automatic logic [N_ENGINES-1:0] engine_route(input logic [7:0] ctype);
    case (ctype)
      TYPE_MAIN:   engine_route = 3'b001;
      TYPE_COPROC: engine_route = 3'b010;
      TYPE_STILL:  engine_route = 3'b100;
      default:     engine_route = 3'b000;
    endcase
  endfunction

  function automatic logic [11:0] err_offset(input int unsigned idx);
    case (idx)
      0:       err_offset = OFS_ERR_LOC;
      1:       err_offset = OFS_ERR_EXT;
      default: err_offset = OFS_ERR_SEC;
    endcase
  endfunction

endpackage

// File: rtl/hostq_fifo.sv
module hostq_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [LW-1:0]    level
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    bump = (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign do_push = push && (level != LW'(DEPTH));
  assign do_pop  = pop && (level != '0);
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wr_ptr] <= din;
  end

endmodule

// File: rtl/host_cmd_pair.sv
module host_cmd_pair (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output logic        cmd_valid,
  output logic [31:0] cmd_hdr,
  output logic [31:0] cmd_desc
);

  logic        pending_q;
  logic [31:0] hdr_q;

  // The second write of a pair completes the command in the same cycle.
  assign cmd_valid = wr_en && pending_q;
  assign cmd_hdr   = hdr_q;
  assign cmd_desc  = wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      hdr_q     <= '0;
    end else if (flush) begin
      pending_q <= 1'b0;
    end else if (wr_en) begin
      pending_q <= !pending_q;
      if (!pending_q) hdr_q <= wdata;
    end
  end

endmodule

// File: rtl/host_task_dispatch.sv
module host_task_dispatch
  import enc_host_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [31:0]          head_hdr,
  input  logic [31:0]          head_desc,
  input  logic                 cmd_empty,
  input  logic [N_ENGINES-1:0] gate_en,
  input  logic                 stat_full,
  input  logic                 rej_valid,
  input  logic [23:0]          rej_ids,
  output logic                 cmd_pop,
  output logic                 stat_push,
  output logic [31:0]          stat_word,
  output logic                 eng_cmd_valid,
  input  logic                 eng_cmd_ready,
  output logic [31:0]          eng_cmd_word,
  output logic [31:0]          eng_cmd_desc,
  input  logic                 eng_res_valid,
  output logic                 eng_res_ready,
  input  logic [7:0]           eng_res_code
);

  logic                 busy_q;
  logic [23:0]          ids_q;
  logic [N_ENGINES-1:0] route;
  logic                 known, gate_ok, dispatch, rej_push, res_fire, bad_push;
  host_word_t           word;

  assign route   = engine_route(head_hdr[7:0]);
  assign known   = |route;
  assign gate_ok = |(route & gate_en);

  assign eng_cmd_valid = !busy_q && !cmd_empty && gate_ok;
  assign eng_cmd_word  = head_hdr;
  assign eng_cmd_desc  = head_desc;
  assign dispatch      = eng_cmd_valid && eng_cmd_ready;

  // Status slot priority: list-full report, engine result, unknown command.
  assign rej_push      = rej_valid && !stat_full;
  assign eng_res_ready = busy_q && !stat_full && !rej_valid;
  assign res_fire      = eng_res_valid && eng_res_ready;
  assign bad_push      = !busy_q && !cmd_empty && !known && !stat_full && !rej_valid;

  assign cmd_pop   = dispatch || bad_push;
  assign stat_push = rej_push || res_fire || bad_push;

  always_comb begin
    if (rej_push)      word = {rej_ids, CODE_LIST_FULL};
    else if (res_fire) word = {ids_q, eng_res_code};
    else               word = {head_hdr[31:8], CODE_BAD_CMD};
  end
  assign stat_word = word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ids_q  <= '0;
    end else if (dispatch) begin
      busy_q <= 1'b1;
      ids_q  <= head_hdr[31:8];
    end else if (res_fire) begin
      busy_q <= 1'b0;
    end
  end

endmodule

// File: rtl/enc_host_if.sv
module enc_host_if
  import enc_host_pkg::*;
#(
  parameter int          ADDR_W     = 12,
  parameter int          CMD_DEPTH  = 4,
  parameter int          STAT_DEPTH = 8,
  parameter logic [15:0] VERSION_ID = 16'h4A10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              eng_cmd_valid,
  input  logic              eng_cmd_ready,
  output logic [31:0]       eng_cmd_word,
  output logic [31:0]       eng_cmd_desc,
  input  logic              eng_res_valid,
  output logic              eng_res_ready,
  input  logic [7:0]        eng_res_code,
  input  logic [31:0]       err_local_in,
  input  logic [31:0]       err_ext_in,
  input  logic [31:0]       err_sec_in,
  output logic              irq_done,
  output logic              irq_err,
  output logic [2:0]        gate_en,
  output logic [31:0]       mif_cfg,
  output logic [31:0]       mif2_cfg,
  output logic [31:0]       bswap_cfg
);

  localparam int CMD_LW  = $clog2(CMD_DEPTH + 1);
  localparam int STAT_LW = $clog2(STAT_DEPTH + 1);

  localparam logic [ADDR_W-1:0] A_SRST     = ADDR_W'(OFS_SRST);
  localparam logic [ADDR_W-1:0] A_SRST_ACK = ADDR_W'(OFS_SRST_ACK);
  localparam logic [ADDR_W-1:0] A_MIF      = ADDR_W'(OFS_MIF);
  localparam logic [ADDR_W-1:0] A_MIF2     = ADDR_W'(OFS_MIF2);
  localparam logic [ADDR_W-1:0] A_CMDQ     = ADDR_W'(OFS_CMDQ);
  localparam logic [ADDR_W-1:0] A_STATQ    = ADDR_W'(OFS_STATQ);
  localparam logic [ADDR_W-1:0] A_LEVEL    = ADDR_W'(OFS_LEVEL);
  localparam logic [ADDR_W-1:0] A_IRQACK   = ADDR_W'(OFS_IRQACK);
  localparam logic [ADDR_W-1:0] A_ERR_LOC  = ADDR_W'(OFS_ERR_LOC);
  localparam logic [ADDR_W-1:0] A_ERR_EXT  = ADDR_W'(OFS_ERR_EXT);
  localparam logic [ADDR_W-1:0] A_ERR_SEC  = ADDR_W'(OFS_ERR_SEC);
  localparam logic [ADDR_W-1:0] A_GATE     = ADDR_W'(OFS_GATE);
  localparam logic [ADDR_W-1:0] A_VER      = ADDR_W'(OFS_VER);
  localparam logic [ADDR_W-1:0] A_BSWAP    = ADDR_W'(OFS_BSWAP);

  logic wr, rd, flush, ack;
  assign wr    = bus_req && bus_we;
  assign rd    = bus_req && !bus_we;
  assign flush = wr && (bus_addr == A_SRST) && bus_wdata[0];
  assign ack   = wr && (bus_addr == A_IRQACK) && bus_wdata[0];

  // Command pairing and command queue
  logic        pair_valid;
  logic [31:0] pair_hdr, pair_desc;
  logic [CMD_LW-1:0] cmd_level;
  logic [63:0] cmd_head;
  logic        cmd_full, cmd_pop;

  host_cmd_pair u_pair (
    .clk, .rst_n, .flush,
    .wr_en    (wr && (bus_addr == A_CMDQ)),
    .wdata    (bus_wdata),
    .cmd_valid(pair_valid),
    .cmd_hdr  (pair_hdr),
    .cmd_desc (pair_desc)
  );

  assign cmd_full = (cmd_level == CMD_LW'(CMD_DEPTH));

  hostq_fifo #(.WIDTH(64), .DEPTH(CMD_DEPTH)) u_cmdq (
    .clk, .rst_n, .flush,
    .push (pair_valid && !cmd_full),
    .din  ({pair_hdr, pair_desc}),
    .pop  (cmd_pop),
    .dout (cmd_head),
    .level(cmd_level)
  );

  // Status queue
  logic [STAT_LW-1:0] stat_level;
  logic [31:0] stat_head, stat_word;
  logic        stat_push, stat_pop, stat_empty, stat_full;

  assign stat_empty = (stat_level == '0);
  assign stat_full  = (stat_level == STAT_LW'(STAT_DEPTH));
  assign stat_pop   = rd && (bus_addr == A_STATQ) && !stat_empty;

  hostq_fifo #(.WIDTH(32), .DEPTH(STAT_DEPTH)) u_statq (
    .clk, .rst_n, .flush,
    .push (stat_push),
    .din  (stat_word),
    .pop  (stat_pop),
    .dout (stat_head),
    .level(stat_level)
  );

  host_task_dispatch u_disp (
    .clk, .rst_n,
    .head_hdr     (cmd_head[63:32]),
    .head_desc    (cmd_head[31:0]),
    .cmd_empty    (cmd_level == '0),
    .gate_en      (gate_en),
    .stat_full    (stat_full),
    .rej_valid    (pair_valid && cmd_full),
    .rej_ids      (pair_hdr[31:8]),
    .cmd_pop      (cmd_pop),
    .stat_push    (stat_push),
    .stat_word    (stat_word),
    .eng_cmd_valid(eng_cmd_valid),
    .eng_cmd_ready(eng_cmd_ready),
    .eng_cmd_word (eng_cmd_word),
    .eng_cmd_desc (eng_cmd_desc),
    .eng_res_valid(eng_res_valid),
    .eng_res_ready(eng_res_ready),
    .eng_res_code (eng_res_code)
  );

  // Configuration, flush acknowledge and interrupt flags
  logic srst_ack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_en    <= '0;
      mif_cfg    <= '0;
      mif2_cfg   <= '0;
      bswap_cfg  <= '0;
      srst_ack_q <= 1'b0;
      irq_done   <= 1'b0;
    end else begin
      if (wr && bus_addr == A_GATE)  gate_en   <= bus_wdata[2:0];
      if (wr && bus_addr == A_MIF)   mif_cfg   <= bus_wdata;
      if (wr && bus_addr == A_MIF2)  mif2_cfg  <= bus_wdata;
      if (wr && bus_addr == A_BSWAP) bswap_cfg <= bus_wdata;
      if (flush)                                srst_ack_q <= 1'b1;
      else if (rd && bus_addr == A_SRST_ACK)    srst_ack_q <= 1'b0;
      if (stat_push)  irq_done <= 1'b1;
      else if (ack)   irq_done <= 1'b0;
    end
  end

  // Memory error capture: accumulate, clear on read
  logic [31:0] err_in [N_ERR];
  logic [31:0] err_q  [N_ERR];
  assign err_in[0] = err_local_in;
  assign err_in[1] = err_ext_in;
  assign err_in[2] = err_sec_in;

  for (genvar g = 0; g < N_ERR; g++) begin : g_err
    localparam logic [ADDR_W-1:0] A_THIS = ADDR_W'(err_offset(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        err_q[g] <= '0;
      else if (rd && bus_addr == A_THIS) err_q[g] <= err_in[g];
      else                               err_q[g] <= err_q[g] | err_in[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                      irq_err <= 1'b0;
    else if (|{err_local_in, err_ext_in, err_sec_in}) irq_err <= 1'b1;
    else if (ack)                                    irq_err <= 1'b0;
  end

  // Registered read path
  logic [31:0] rd_mux, lvl32;
  assign lvl32 = 32'(stat_level);

  always_comb begin
    case (bus_addr)
      A_SRST_ACK: rd_mux = {31'b0, srst_ack_q};
      A_MIF:      rd_mux = mif_cfg;
      A_MIF2:     rd_mux = mif2_cfg;
      A_STATQ:    rd_mux = stat_empty ? 32'b0 : stat_head;
      A_LEVEL:    rd_mux = {28'b0, lvl32[3:0]};
      A_ERR_LOC:  rd_mux = err_q[0];
      A_ERR_EXT:  rd_mux = err_q[1];
      A_ERR_SEC:  rd_mux = err_q[2];
      A_GATE:     rd_mux = {29'b0, gate_en};
      A_VER:      rd_mux = {16'b0, VERSION_ID};
      A_BSWAP:    rd_mux = bswap_cfg;
      default:    rd_mux = 32'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  bus_rdata <= '0;
    else if (rd) bus_rdata <= rd_mux;
  end

endmodule

// File: rtl/enc_host_if_chk.sv
module enc_host_if_chk
  import enc_host_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              eng_cmd_valid,
  input logic              eng_cmd_ready,
  input logic [31:0]       eng_cmd_word,
  input logic [31:0]       eng_cmd_desc,
  input logic [31:0]       err_local_in,
  input logic [31:0]       err_ext_in,
  input logic [31:0]       err_sec_in,
  input logic              irq_done,
  input logic              irq_err,
  input logic [2:0]        gate_en
);

  logic host_ack, any_wr, any_err;
  assign any_wr   = bus_req && bus_we;
  assign host_ack = any_wr && (bus_addr == ADDR_W'(OFS_IRQACK)) && ((bus_wdata & 32'h1) != 32'h0);
  assign any_err  = (err_local_in | err_ext_in | err_sec_in) != 32'h0;

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    eng_cmd_valid && !eng_cmd_ready && !any_wr |=> eng_cmd_valid && $stable(eng_cmd_word) && $stable(eng_cmd_desc)); // R2

  AST_GATED_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    eng_cmd_valid |-> ((eng_cmd_word[7:0] == TYPE_MAIN && gate_en[0]) ||
                       (eng_cmd_word[7:0] == TYPE_COPROC && gate_en[1]) ||
                       (eng_cmd_word[7:0] == TYPE_STILL && gate_en[2]))); // R3

  AST_SINGLE_TASK: assert property (@(posedge clk) disable iff (!rst_n)
    eng_cmd_valid && eng_cmd_ready |=> !eng_cmd_valid); // R5

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done && !host_ack |=> irq_done); // R9

  AST_ERR_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    any_err |=> irq_err); // R10

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err && !host_ack |=> irq_err); // R10

endmodule

bind enc_host_if enc_host_if_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/enc_host_if_bench.sv
module enc_host_if_bench;
  import enc_host_pkg::*;

  localparam int          CMD_DEPTH  = 4;
  localparam int          STAT_DEPTH = 8;
  localparam logic [15:0] VER        = 16'h4A10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        eng_cmd_valid, eng_cmd_ready;
  logic [31:0] eng_cmd_word, eng_cmd_desc;
  logic        eng_res_valid, eng_res_ready;
  logic [7:0]  eng_res_code;
  logic [31:0] err_local_in = '0, err_ext_in = '0, err_sec_in = '0;
  logic        irq_done, irq_err;
  logic [2:0]  gate_en;
  logic [31:0] mif_cfg, mif2_cfg, bswap_cfg;

  always #4 clk = ~clk;

  enc_host_if #(.ADDR_W(12), .CMD_DEPTH(CMD_DEPTH), .STAT_DEPTH(STAT_DEPTH), .VERSION_ID(VER)) u_enc_host_if (
    .clk, .rst_n, .bus_req, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
    .eng_cmd_valid, .eng_cmd_ready, .eng_cmd_word, .eng_cmd_desc,
    .eng_res_valid, .eng_res_ready, .eng_res_code,
    .err_local_in, .err_ext_in, .err_sec_in,
    .irq_done, .irq_err, .gate_en, .mif_cfg, .mif2_cfg, .bswap_cfg
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_code(input logic [15:0] t);
    case (t[2:0])
      3'd0: exp_code = 8'h00;
      3'd1: exp_code = 8'h02;
      3'd2: exp_code = 8'h04;
      3'd3: exp_code = 8'h05;
      3'd4: exp_code = 8'h07;
      3'd5: exp_code = 8'h08;
      3'd6: exp_code = 8'hF4;
      default: exp_code = 8'h00;
    endcase
  endfunction

  // Engine model: accepts commands, answers after eng_delay cycles.
  int          eng_cnt = 0, eng_delay = 0, m_cnt = 0;
  bit          m_busy = 0, drop_next = 0;
  logic [15:0] m_task = '0;
  logic [31:0] last_hdr = '0, last_desc = '0;

  initial begin
    eng_cmd_ready = 1'b1;
    eng_res_valid = 1'b0;
    eng_res_code  = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (drop_next) begin eng_res_valid = 1'b0; drop_next = 0; end
        if (m_busy && !eng_res_valid) begin
          if (m_cnt > 0) m_cnt--;
          else begin eng_res_valid = 1'b1; eng_res_code = exp_code(m_task); end
        end
        #1;
        if (eng_res_valid && eng_res_ready) begin drop_next = 1; m_busy = 0; end
        if (eng_cmd_valid && eng_cmd_ready) begin
          last_hdr = eng_cmd_word; last_desc = eng_cmd_desc;
          m_task = eng_cmd_word[31:16]; m_busy = 1; m_cnt = eng_delay; eng_cnt++;
        end
      end
    end
  end

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
    d = bus_rdata;
  endtask

  task automatic send_cmd(input logic [15:0] t, input logic [7:0] c, input logic [7:0] ty, input logic [31:0] desc);
    bus_wr(OFS_CMDQ, {t, c, ty});
    bus_wr(OFS_CMDQ, desc);
  endtask

  task automatic wait_level(input int n);
    logic [31:0] v;
    for (int i = 0; i < 300; i++) begin
      bus_rd(OFS_LEVEL, v);
      if (v[3:0] >= 4'(n)) break;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq_done", {31'b0, irq_done}, 32'h0);
    check("R1 irq_err", {31'b0, irq_err}, 32'h0);
    check("R1 gate_en", {29'b0, gate_en}, 32'h0);
    check("R1 eng_cmd_valid", {31'b0, eng_cmd_valid}, 32'h0);
    bus_rd(OFS_LEVEL, v); check("R1 level", v, 32'h0);
    bus_rd(OFS_STATQ, v); check("R1 R6 empty status read", v, 32'h0);

    // R11 version, write ignored
    bus_rd(OFS_VER, v); check("R11 version", v, {16'h0, VER});
    bus_wr(OFS_VER, 32'hFFFF_FFFF);
    bus_rd(OFS_VER, v); check("R11 version after write", v, {16'h0, VER});

    // R12 configuration registers
    bus_wr(OFS_GATE, 32'hFFFF_FFFF);
    bus_rd(OFS_GATE, v); check("R12 gate read", v, 32'h7);
    check("R12 gate port", {29'b0, gate_en}, 32'h7);
    bus_wr(OFS_MIF, 32'h0446_0806);  bus_rd(OFS_MIF, v);  check("R12 mif", v, 32'h0446_0806);
    bus_wr(OFS_MIF2, 32'h0000_00C4); bus_rd(OFS_MIF2, v); check("R12 mif2", v, 32'h0000_00C4);
    bus_wr(OFS_BSWAP, 32'h003F_0000); bus_rd(OFS_BSWAP, v); check("R12 bswap", v, 32'h003F_0000);
    check("R12 mif port", mif_cfg, 32'h0446_0806);
    check("R12 mif2 port", mif2_cfg, 32'h0000_00C4);
    check("R12 bswap port", bswap_cfg, 32'h003F_0000);

    // Sweep: every engine type, several clients, tasks and delays (R2 R5 R6 R7 R9)
    for (int ty = 1; ty <= 3; ty++) begin
      for (int cl = 0; cl < 4; cl++) begin
        logic [15:0] t;
        logic [31:0] d;
        t = 16'(ty * 16 + cl * 5);
        d = 32'h1000_0000 + 32'(ty * 256 + cl);
        eng_delay = cl;
        send_cmd(t, 8'(cl + 1), 8'(ty), d);
        wait_level(1);
        check("R2 engine header", last_hdr, {t, 8'(cl + 1), 8'(ty)});
        check("R2 engine descriptor", last_desc, d);
        check("R9 irq_done set", {31'b0, irq_done}, 32'h1);
        bus_rd(OFS_STATQ, v); check("R5 status word", v, {t, 8'(cl + 1), exp_code(t)});
        bus_rd(OFS_STATQ, v); check("R6 empty read", v, 32'h0);
        bus_rd(OFS_LEVEL, v); check("R7 level drained", v, 32'h0);
        bus_wr(OFS_IRQACK, 32'h1);
        check("R9 irq_done cleared", {31'b0, irq_done}, 32'h0);
      end
    end
    check("R5 engine count", 32'(eng_cnt), 32'd12);

    // R4 unknown command types
    base = eng_cnt;
    foreach (v[i]) begin end
    for (int k = 0; k < 4; k++) begin
      logic [7:0] ty;
      ty = (k == 0) ? 8'h00 : (k == 1) ? 8'h04 : (k == 2) ? 8'h80 : 8'hFF;
      send_cmd(16'(16'h0500 + k), 8'h21, ty, 32'hDEAD_0000);
      wait_level(1);
      bus_rd(OFS_STATQ, v); check("R4 unknown type status", v, {16'(16'h0500 + k), 8'h21, CODE_BAD_CMD});
    end
    check("R4 no engine offer", 32'(eng_cnt), 32'(base));

    // R3 clock-enable gating
    base = eng_cnt;
    bus_wr(OFS_GATE, 32'h6);
    send_cmd(16'h0300, 8'h05, TYPE_MAIN, 32'hA000_0300);
    repeat (16) @(negedge clk);
    check("R3 gated not offered", {31'b0, eng_cmd_valid}, 32'h0);
    check("R3 gated engine count", 32'(eng_cnt), 32'(base));
    bus_rd(OFS_LEVEL, v); check("R3 gated level", v, 32'h0);
    bus_wr(OFS_GATE, 32'h1);
    wait_level(1);
    bus_rd(OFS_STATQ, v); check("R3 released status", v, {16'h0300, 8'h05, exp_code(16'h0300)});

    // R8 command list full, R5 ordering
    bus_wr(OFS_GATE, 32'h0);
    eng_delay = 1;
    for (int k = 0; k < CMD_DEPTH; k++) send_cmd(16'(16'h0200 + k), 8'h09, TYPE_MAIN, 32'(k));
    send_cmd(16'h02FF, 8'h0A, TYPE_MAIN, 32'h55);
    bus_rd(OFS_LEVEL, v); check("R8 reject queued", v, 32'h1);
    bus_rd(OFS_STATQ, v); check("R8 list full word", v, {16'h02FF, 8'h0A, CODE_LIST_FULL});
    bus_wr(OFS_GATE, 32'h1);
    wait_level(CMD_DEPTH);
    for (int k = 0; k < CMD_DEPTH; k++) begin
      bus_rd(OFS_STATQ, v);
      check("R5 completion order", v, {16'(16'h0200 + k), 8'h09, exp_code(16'(16'h0200 + k))});
    end

    // R14 back-pressure with full status queue
    eng_delay = 0;
    for (int k = 0; k < STAT_DEPTH; k++) send_cmd(16'(16'h0600 + k), 8'h30, 8'hEE, 32'h0);
    bus_rd(OFS_LEVEL, v); check("R7 full level", v, 32'(STAT_DEPTH));
    send_cmd(16'h0611, 8'h31, TYPE_MAIN, 32'h0611);
    repeat (20) @(negedge clk);
    check("R14 result held", {31'b0, eng_res_valid}, 32'h1);
    check("R14 ready low", {31'b0, eng_res_ready}, 32'h0);
    bus_rd(OFS_LEVEL, v); check("R14 level unchanged", v, 32'(STAT_DEPTH));
    for (int k = 0; k < STAT_DEPTH; k++) begin
      bus_rd(OFS_STATQ, v);
      check("R14 drained unknown", v, {16'(16'h0600 + k), 8'h30, CODE_BAD_CMD});
    end
    bus_rd(OFS_STATQ, v); check("R14 held result", v, {16'h0611, 8'h31, exp_code(16'h0611)});
    bus_wr(OFS_IRQACK, 32'h1);

    // R10 error capture
    @(negedge clk); err_local_in = 32'h5;
    @(negedge clk); err_local_in = 32'h10;
    @(negedge clk); err_local_in = 32'h0;
    check("R10 irq_err raised", {31'b0, irq_err}, 32'h1);
    bus_rd(OFS_ERR_LOC, v); check("R10 local accumulated", v, 32'h15);
    bus_rd(OFS_ERR_LOC, v); check("R10 local cleared", v, 32'h0);
    @(negedge clk); err_ext_in = 32'h8000_0000;
    @(negedge clk); err_ext_in = 32'h0; err_sec_in = 32'h3;
    @(negedge clk); err_sec_in = 32'h0;
    bus_rd(OFS_ERR_EXT, v); check("R10 external", v, 32'h8000_0000);
    bus_rd(OFS_ERR_SEC, v); check("R10 secondary", v, 32'h3);
    bus_rd(OFS_ERR_SEC, v); check("R10 secondary cleared", v, 32'h0);
    check("R10 irq_err held", {31'b0, irq_err}, 32'h1);
    bus_wr(OFS_IRQACK, 32'h1);
    check("R9 R10 ack clears irq_err", {31'b0, irq_err}, 32'h0);

    // R13 soft flush
    bus_wr(OFS_GATE, 32'h0);
    send_cmd(16'h0700, 8'h01, TYPE_MAIN, 32'h1);
    send_cmd(16'h0701, 8'h01, TYPE_MAIN, 32'h2);
    send_cmd(16'h0702, 8'h01, 8'hEE, 32'h3);
    bus_wr(OFS_CMDQ, {16'h0703, 8'h01, TYPE_MAIN});
    bus_wr(OFS_SRST, 32'h1);
    bus_rd(OFS_LEVEL, v); check("R13 status flushed", v, 32'h0);
    bus_rd(OFS_SRST_ACK, v); check("R13 flush ack set", v, 32'h1);
    bus_rd(OFS_SRST_ACK, v); check("R13 flush ack cleared", v, 32'h0);
    base = eng_cnt;
    bus_wr(OFS_GATE, 32'h1);
    send_cmd(16'h0777, 8'h03, TYPE_MAIN, 32'h0777);
    wait_level(1);
    bus_rd(OFS_STATQ, v); check("R13 pairing restarted", v, {16'h0777, 8'h03, exp_code(16'h0777)});
    bus_rd(OFS_LEVEL, v); check("R13 nothing else queued", v, 32'h0);
    check("R13 one dispatch", 32'(eng_cnt), 32'(base + 1));

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule